// File: doc/BRIEF.md
# SD Host Vendor Register Front-End

This block is the register front-end placed ahead of a standard SD host controller slot. It decodes a 4 KiB window of aligned 32-bit accesses. The lower 512 bytes form 128 vendor host words that it keeps itself. Accesses at or above byte offset 0x200 go out on a slot port, which is handshaked, to the standard slot register set that sits behind it.

Three host words react to writes in special ways:
- The information word at offset 0x00 holds a fixed value. Writing bit 0 of it restores every host word and sends a one-cycle reset pulse to the slot controller.
- The PHY access word at offset 0x10 raises its acknowledge bit whenever a read or write request bit is written.
- The eMMC control word at offset 0x18 never stores its tune-request bit.

The slot controller's interrupt passes straight through the block.

A requester presents one request at a time with `req_valid`, and the request is taken on a clock edge where `req_ready` is high. Every accepted request returns exactly one `rsp_valid` pulse. For host words that pulse comes one cycle after acceptance. For the slot region it comes one cycle after the slot port completes.

Top module: `sdhc_vendor_regs`

## Requirements
- R1: After reset, the word at offset 0x00 reads 0x00010000 and every other host word (offsets 0x004 to 0x1FC) reads 0.
- R2: An aligned write at an offset below 0x200, other than 0x00, 0x10 and 0x18, stores the 32-bit data in word offset>>2, and a later read returns it. Other words are unchanged.
- R3: A write to offset 0x00 never changes that word, and bit 0 always reads back as 0. If the write has bit 0 set, all host words return to their R1 values and `slot_rst` is high for exactly one cycle, the cycle after acceptance.
- R4: A write to offset 0x10 stores the data with bit 26 forced to 1 if bit 24 or bit 25 of the data is set, and forced to 0 otherwise. All other bits are stored as written.
- R5: A write to offset 0x18 stores the data with bit 15 cleared and all other bits as written.
- R6: An aligned access at offset 0x200 or above raises `slot_valid` with `slot_addr` = offset − 0x200 and the request's direction and data. These stay stable until `slot_ready` is seen, and host words are unaffected.
- R7: While a slot access is pending, `req_ready` is low. One cycle after the `slot_valid`/`slot_ready` handshake, `rsp_valid` pulses with the slot read data for a read, or 0 for a write.
- R8: For an accepted access to the host region, `rsp_valid` is high in the following cycle. `rsp_rdata` holds the word's value for a read and 0 for a write.
- R9: An access with offset bits [1:0] not zero changes no host word, starts no slot access, and returns a response with data 0 one cycle later.
- R10: `irq` equals `slot_irq` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Response data |
| slot_valid | output | 1 | Slot access pending |
| slot_write | output | 1 | Slot access direction |
| slot_addr | output | 12 | Byte offset inside the slot set |
| slot_wdata | output | 32 | Slot write data |
| slot_ready | input | 1 | Slot access completes |
| slot_rdata | input | 32 | Slot read data |
| slot_rst | output | 1 | One-cycle reset pulse to the slot controller |
| slot_irq | input | 1 | Interrupt from the slot controller |
| irq | output | 1 | Interrupt output |

## Verification
A corrupted host word shows up on the next read of that word, one cycle after the read is accepted. It also shows up through the PHY and eMMC words, whose stored value is a visible function of the written data. A wrong decode of the slot boundary or of alignment shows up in two ways. Either `slot_valid` rises when it should not, or a read returns a value that depends on the forwarded slot offset, so the offset arithmetic is observed directly. A broken reset path shows up in the pulse count on `slot_rst` and in the host words read back right after the reset write.

// File: rtl/sdhc_vendor_regs.sv
module sdhc_vendor_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SLOT_BASE = 'h200,
  parameter logic [DATA_W-1:0] INFO_RST = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              slot_valid,
  output logic              slot_write,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_wdata,
  input  logic              slot_ready,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              slot_rst,
  input  logic              slot_irq,
  output logic              irq
);
  localparam int HOST_WORDS = SLOT_BASE / 4;
  localparam int IDX_W      = $clog2(HOST_WORDS);
  localparam int INFO_IDX   = 0;
  localparam int PHY_IDX    = 4;
  localparam int EMMC_IDX   = 6;
  localparam int SWR_BIT    = 0;
  localparam int PHY_WR_BIT = 24;
  localparam int PHY_RD_BIT = 25;
  localparam int PHY_ACK    = 26;
  localparam int TUNE_BIT   = 15;

  logic [DATA_W-1:0] regs [HOST_WORDS];
  logic [DATA_W-1:0] wr_val;
  logic [IDX_W-1:0]  idx;
  logic aligned, in_slot, accept, host_acc, host_wr, swr, slot_done;

  assign idx       = req_addr[IDX_W+1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign in_slot   = (req_addr >= ADDR_W'(SLOT_BASE));
  assign req_ready = ~slot_valid;
  assign accept    = req_valid & req_ready;
  assign host_acc  = accept & aligned & ~in_slot;
  assign host_wr   = host_acc & req_write;
  assign swr       = host_wr && (idx == IDX_W'(INFO_IDX)) && req_wdata[SWR_BIT];
  assign slot_done = slot_valid & slot_ready;
  assign irq       = slot_irq;

  always_comb begin
    wr_val = req_wdata;
    if (idx == IDX_W'(PHY_IDX))
      wr_val[PHY_ACK] = req_wdata[PHY_WR_BIT] | req_wdata[PHY_RD_BIT];
    if (idx == IDX_W'(EMMC_IDX))
      wr_val[TUNE_BIT] = 1'b0;
  end

  for (genvar i = 0; i < HOST_WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] RV = (i == INFO_IDX) ? INFO_RST : '0;
    localparam bit WRITABLE = (i != INFO_IDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RV;
      else if (swr)
        regs[i] <= RV;
      else if (WRITABLE && host_wr && idx == IDX_W'(i))
        regs[i] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      slot_rst  <= 1'b0;
    end else begin
      rsp_valid <= (accept & ~(aligned & in_slot)) | slot_done;
      slot_rst  <= swr;
      if (slot_done)
        rsp_rdata <= slot_write ? '0 : slot_rdata;
      else if (host_acc && !req_write)
        rsp_rdata <= regs[idx];
      else
        rsp_rdata <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_write <= 1'b0;
      slot_addr  <= '0;
      slot_wdata <= '0;
    end else if (accept && aligned && in_slot) begin
      slot_valid <= 1'b1;
      slot_write <= req_write;
      slot_addr  <= req_addr - ADDR_W'(SLOT_BASE);
      slot_wdata <= req_wdata;
    end else if (slot_ready) begin
      slot_valid <= 1'b0;
    end
  end

  AST_SWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && req_addr == '0 && req_wdata[SWR_BIT]) |=> (slot_rst && regs[PHY_IDX] == '0)); // R3
  AST_INFO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    regs[INFO_IDX] == INFO_RST); // R3
  AST_ACK_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && idx == IDX_W'(PHY_IDX)) |=> (regs[PHY_IDX][PHY_ACK] == ($past(req_wdata[PHY_WR_BIT]) | $past(req_wdata[PHY_RD_BIT])))); // R4
  AST_TUNE_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[EMMC_IDX][TUNE_BIT]); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_addr) && $stable(slot_write) && $stable(slot_wdata))); // R6
  AST_SLOT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_ready) |=> (rsp_valid && !slot_valid)); // R7
  AST_HOST_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |=> rsp_valid); // R8
  AST_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !aligned) |=> (!slot_valid && rsp_valid && rsp_rdata == '0)); // R9
endmodule

// File: tb/sdhc_vendor_regs_tb.sv
`timescale 1ns/1ps
module sdhc_vendor_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, slot_valid, slot_write, slot_rst, irq;
  logic [31:0] rsp_rdata, slot_wdata, slot_rdata;
  logic [11:0] slot_addr;
  logic slot_ready = 1'b0;
  logic slot_irq = 1'b0;
  logic [1:0] scnt = '0;
  logic [11:0] lw_addr = '0;
  logic [31:0] lw_data = '0;
  int n_chk = 0, n_fail = 0, rst_pulses = 0, slot_starts = 0;
  bit sv_d = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sdhc_vendor_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slot_valid(slot_valid),
    .slot_write(slot_write), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
    .slot_ready(slot_ready), .slot_rdata(slot_rdata), .slot_rst(slot_rst),
    .slot_irq(slot_irq), .irq(irq));

  assign slot_rdata = {20'h5A000, slot_addr};

  always @(posedge clk) begin
    if (!rst_n) begin
      slot_ready <= 1'b0; scnt <= '0;
    end else if (slot_ready) begin
      slot_ready <= 1'b0; scnt <= '0;
    end else if (slot_valid) begin
      if (scnt == 2'd1) slot_ready <= 1'b1;
      else scnt <= scnt + 2'd1;
    end
    if (slot_valid && slot_ready && slot_write) begin
      lw_addr <= slot_addr; lw_data <= slot_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (slot_rst) rst_pulses++;
      if (slot_valid && !sv_d) slot_starts++;
      sv_d = slot_valid;
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", rsp_rdata, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    bit to_slot;
    to_slot = (a >= 12'h200) && (a[1:0] == 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(wr ? 32'h0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    if (to_slot) chk(!req_ready, {tag, " R7 busy"}, {31'h0, req_ready}, 32'h0);
    else         chk(rsp_valid, {tag, " R8 latency"}, {31'h0, rsp_valid}, 32'h1);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    int starts0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    acc(0, 12'h000, 0, 32'h0001_0000, "R1 info reset");
    acc(0, 12'h004, 0, 32'h0, "R1 word1 reset");
    acc(0, 12'h1FC, 0, 32'h0, "R1 last word reset");
    acc(0, 12'h010, 0, 32'h0, "R1 phy reset");
    chk(rst_pulses == 0, "R3 no pulse at reset", rst_pulses, 0);
    // R2 plain storage
    acc(1, 12'h004, 32'hDEAD_BEEF, 0, "R2 write");
    acc(1, 12'h1FC, 32'h1234_5678, 0, "R2 write");
    acc(1, 12'h008, 32'hA5A5_0F0F, 0, "R2 write");
    acc(0, 12'h004, 0, 32'hDEAD_BEEF, "R2 word1");
    acc(0, 12'h1FC, 0, 32'h1234_5678, "R2 last word");
    acc(0, 12'h008, 0, 32'hA5A5_0F0F, "R2 word2");
    // R4 acknowledge
    acc(1, 12'h010, 32'h0100_0000, 0, "R4 write");
    acc(0, 12'h010, 0, 32'h0500_0000, "R4 wr req ack");
    acc(1, 12'h010, 32'h0200_0055, 0, "R4 write");
    acc(0, 12'h010, 0, 32'h0600_0055, "R4 rd req ack");
    acc(1, 12'h010, 32'h0400_00FF, 0, "R4 write");
    acc(0, 12'h010, 0, 32'h0000_00FF, "R4 ack dropped");
    acc(1, 12'h010, 32'h0300_0000, 0, "R4 write");
    acc(0, 12'h010, 0, 32'h0700_0000, "R4 both req");
    // R5 tune bit
    acc(1, 12'h018, 32'hFFFF_FFFF, 0, "R5 write");
    acc(0, 12'h018, 0, 32'hFFFF_7FFF, "R5 tune cleared");
    acc(1, 12'h018, 32'h0000_8000, 0, "R5 write");
    acc(0, 12'h018, 0, 32'h0000_0000, "R5 tune only");
    // R3 info word without reset bit
    acc(1, 12'h000, 32'hFFFF_FFFE, 0, "R3 write info");
    acc(0, 12'h000, 0, 32'h0001_0000, "R3 info unchanged");
    acc(0, 12'h004, 0, 32'hDEAD_BEEF, "R3 no reset without bit0");
    chk(rst_pulses == 0, "R3 no pulse without bit0", rst_pulses, 0);
    // R6 R7 slot region
    acc(0, 12'h234, 0, 32'h5A00_0034, "R7 slot read");
    acc(0, 12'hFFC, 0, 32'h5A00_0DFC, "R7 slot read top");
    acc(1, 12'h300, 32'hCAFE_F00D, 0, "R6 slot write");
    chk(lw_addr == 12'h100, "R6 slot addr", {20'h0, lw_addr}, 32'h100);
    chk(lw_data == 32'hCAFE_F00D, "R6 slot data", lw_data, 32'hCAFE_F00D);
    acc(0, 12'h004, 0, 32'hDEAD_BEEF, "R6 host untouched");
    // R9 misaligned
    starts0 = slot_starts;
    acc(1, 12'h006, 32'h1111_1111, 0, "R9 misaligned write");
    acc(0, 12'h004, 0, 32'hDEAD_BEEF, "R9 word unchanged");
    acc(0, 12'h006, 0, 32'h0, "R9 misaligned read");
    acc(0, 12'h202, 0, 32'h0, "R9 misaligned slot read");
    chk(slot_starts == starts0, "R9 no slot access", slot_starts, starts0);
    // R10 interrupt
    slot_irq = 1'b1; #1;
    chk(irq == 1'b1, "R10 irq high", {31'h0, irq}, 32'h1);
    slot_irq = 1'b0; #1;
    chk(irq == 1'b0, "R10 irq low", {31'h0, irq}, 32'h0);
    // R3 software reset
    acc(1, 12'h000, 32'h0000_0001, 0, "R3 swr");
    @(negedge clk);
    chk(rst_pulses == 1, "R3 one pulse", rst_pulses, 1);
    acc(0, 12'h000, 0, 32'h0001_0000, "R3 info after swr");
    acc(0, 12'h004, 0, 32'h0, "R3 word1 after swr");
    acc(0, 12'h010, 0, 32'h0, "R3 phy after swr");
    acc(0, 12'h1FC, 0, 32'h0, "R3 last after swr");
    chk(rst_pulses == 1, "R3 pulse width", rst_pulses, 1);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule